// File: doc/BRIEF.md
# Extended PRG/CHR bank address mapper

This block holds the banking state of a cartridge and turns the addresses that the console puts on its buses into wide physical ROM addresses. On the program side, a 15-bit offset into the $8000–$FFFF window becomes a 12-bit 8K bank number followed by 13 offset bits. On the pattern side, a 13-bit address in $0000–$1FFF becomes a 15-bit 1K bank number followed by 10 offset bits. A single output selects horizontal or vertical nametable mirroring.

The banking state is loaded over one write port from three places. Two 16-entry register files sit at $4100–$410F and $2010–$201F. The classic command/data pair sits in the $8000 region, decoded with mask $E001, together with a mirroring register. On top of ordinary 8K/1K banking, a size field picks how many low bank bits come from the slot registers. An outer block, built from high register bits, supplies the rest.

Translation is purely combinational from the stored state. A write takes effect on the clock edge that samples it. The bench and the surrounding logic can therefore read the new mapping straight after that edge.

Top module: `xbank_mapper`

## Requirements
- R1: After reset every banking register, the command and the mirroring bit read as zero. Program windows $8000/$A000/$C000/$E000 then map to 8K banks 0x00, 0x00, 0x3E and 0x3F, pattern slots 0–7 map to 1K banks 0,1,0,1,0,0,0,0, and `mirror_horiz` is 0.
- R2: A write whose address ANDed with $E001 equals $8000 loads command bits 7, 6 and 2:0 from the data. Command bits 5:3 stay zero.
- R3: A write decoded as $8001 stores the data according to command bits 2:0. Indices 0..5 go to pattern registers 6, 7, 2, 3, 4, 5, index 6 goes to program register 7 and index 7 goes to program register 8. The same registers are also writable directly at $2012–$2017 and $4107–$4108.
- R4: The program size field is $410B bits 2:0. The program mask is 0xFF for size 7 and 0x3F shifted right by the size otherwise. The outer program block is ($4100 bits 7:4) × 256 plus ($410A AND NOT mask).
- R5: Program bank = outer block OR (value AND mask). Window values: window 0 uses register 7, window 1 uses register 8, window 2 uses register 9 when $410B bit 6 is 1 and 0xFE when it is 0, and window 3 uses 0xFF.
- R6: Command bit 6 exchanges the sources of program windows $8000 and $C000. Windows $A000 and $E000 are unaffected.
- R7: The pattern mask is 0xFF shifted right by {0,1,2,0,3,4,5,0}[$201A bits 2:0]. The pattern block is ($4100 bits 3:0) × 2048 plus ($2018 bits 6:4) × 256 plus ($201A AND NOT mask).
- R8: Pattern bank = block OR (value AND mask). Slots 0–3 use register 6 with bit 0 cleared, register 6 with bit 0 set, register 7 with bit 0 cleared and register 7 with bit 0 set. Slots 4–7 use registers 2, 3, 4, 5.
- R9: Command bit 7 exchanges the $0000–$0FFF and $1000–$1FFF halves of the pattern space.
- R10: A write decoded as $A000 sets `mirror_horiz` to data bit 0 (1 = horizontal, 0 = vertical).
- R11: Writes to $4101–$4104, and writes in $8000–$FFFF other than the $8000/$8001/$A000 decodes, change no output.
- R12: The low 13 program bits equal `cpu_addr[12:0]` and the low 10 pattern bits equal `ppu_addr[9:0]`. Both outputs follow address changes within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 15 | Offset into the $8000–$FFFF program window |
| ppu_addr | input | 13 | Pattern address $0000–$1FFF |
| prg_addr | output | 25 | {8K bank, 13-bit offset} |
| chr_addr | output | 25 | {1K bank, 10-bit offset} |
| mirror_horiz | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
A register write is due one clock edge after the strobe is sampled: the new mapping is visible on both address outputs right after that edge. Address changes show up in zero cycles, since translation is combinational. After each write, the bench updates its behavioural model just past the sampling edge. It then sweeps every program window and pattern slot in small steps that all finish before the next falling edge. On every falling edge it also compares whatever addresses are applied at that moment.

// File: rtl/xbank_pkg.sv
`timescale 1ns/1ps
package xbank_pkg;

    localparam int PRG_OFF_W  = 13;
    localparam int CHR_OFF_W  = 10;
    localparam int PRG_BANK_W = 12;
    localparam int CHR_BANK_W = 15;
    localparam int REG_W      = 8;
    localparam int PRG_WIN    = 4;
    localparam int CHR_SLOTS  = 8;
    localparam int PRG_SEL_W  = $clog2(PRG_WIN);
    localparam int CHR_SEL_W  = $clog2(CHR_SLOTS);
    localparam int PRG_W      = PRG_BANK_W + PRG_OFF_W;
    localparam int CHR_W      = CHR_BANK_W + CHR_OFF_W;

    typedef logic [REG_W-1:0] reg8_t;

    typedef struct packed {
        reg8_t                 outer;      // high nibble program, low nibble pattern
        reg8_t                 prg_a;      // window 0 source
        reg8_t                 prg_b;      // window 1 source
        reg8_t                 prg_c;      // optional window 2 source
        reg8_t                 prg_base;   // block bits under the mask
        logic                  prg_c_en;
        logic [2:0]            prg_size;
        reg8_t [5:0]           chr_sel;    // pattern registers 2..7
        logic [2:0]            chr_hi;
        reg8_t                 chr_cfg;    // size index and block bits
        logic                  swap_chr;
        logic                  swap_prg;
        logic [2:0]            cmd_idx;
        logic                  mirror_h;
    } map_state_t;

    function automatic reg8_t prg_mask(input logic [2:0] size);
        return (size == 3'd7) ? 8'hFF : (8'h3F >> size);
    endfunction

    function automatic logic [2:0] chr_shift(input logic [2:0] idx);
        case (idx)
            3'd1:    return 3'd1;
            3'd2:    return 3'd2;
            3'd4:    return 3'd3;
            3'd5:    return 3'd4;
            3'd6:    return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/xbank_regs.sv
`timescale 1ns/1ps
module xbank_regs
    import xbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output map_state_t       st
);

    logic        hit_cpu_file;
    logic        hit_ppu_file;
    logic [15:0] legacy_key;
    logic [3:0]  sub;

    assign hit_cpu_file = (wr_addr[15:4] == 12'h410);
    assign hit_ppu_file = (wr_addr[15:4] == 12'h201);
    assign legacy_key   = wr_addr & 16'hE001;
    assign sub          = wr_addr[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_en) begin
            if (hit_cpu_file) begin
                case (sub)
                    4'h0: st.outer    <= wr_data;
                    4'h7: st.prg_a    <= wr_data;
                    4'h8: st.prg_b    <= wr_data;
                    4'h9: st.prg_c    <= wr_data;
                    4'hA: st.prg_base <= wr_data;
                    4'hB: begin
                        st.prg_c_en <= wr_data[6];
                        st.prg_size <= wr_data[2:0];
                    end
                    default: ;
                endcase
            end else if (hit_ppu_file) begin
                case (sub)
                    4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7:
                        st.chr_sel[sub[2:0] - 3'd2] <= wr_data;
                    4'h8: st.chr_hi  <= wr_data[6:4];
                    4'hA: st.chr_cfg <= wr_data;
                    default: ;
                endcase
            end else begin
                case (legacy_key)
                    16'h8000: begin
                        st.swap_chr <= wr_data[7];
                        st.swap_prg <= wr_data[6];
                        st.cmd_idx  <= wr_data[2:0];
                    end
                    16'h8001: begin
                        case (st.cmd_idx)
                            3'd0: st.chr_sel[4] <= wr_data;
                            3'd1: st.chr_sel[5] <= wr_data;
                            3'd2: st.chr_sel[0] <= wr_data;
                            3'd3: st.chr_sel[1] <= wr_data;
                            3'd4: st.chr_sel[2] <= wr_data;
                            3'd5: st.chr_sel[3] <= wr_data;
                            3'd6: st.prg_a      <= wr_data;
                            default: st.prg_b   <= wr_data;
                        endcase
                    end
                    16'hA000: st.mirror_h <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/xbank_prg.sv
`timescale 1ns/1ps
module xbank_prg
    import xbank_pkg::*;
(
    input  map_state_t            st,
    input  logic [PRG_OFF_W+1:0]  cpu_addr,
    output logic [PRG_W-1:0]      prg_addr
);

    reg8_t                 mask;
    logic [PRG_BANK_W-1:0] block;
    reg8_t                 src [PRG_WIN];
    logic [PRG_BANK_W-1:0] bank [PRG_WIN];
    logic [PRG_SEL_W-1:0]  win;

    assign mask  = prg_mask(st.prg_size);
    assign block = {st.outer[7:4], 8'h00} | {4'h0, st.prg_base & ~mask};

    assign src[0] = st.prg_a;
    assign src[1] = st.prg_b;
    assign src[2] = st.prg_c_en ? st.prg_c : 8'hFE;
    assign src[3] = 8'hFF;

    for (genvar w = 0; w < PRG_WIN; w++) begin : g_win
        assign bank[w] = block | {4'h0, src[w] & mask};
    end

    // bit 6 of the command trades windows 0 and 2
    assign win = cpu_addr[PRG_OFF_W+1:PRG_OFF_W]
               ^ {st.swap_prg & ~cpu_addr[PRG_OFF_W], 1'b0};

    assign prg_addr = {bank[win], cpu_addr[PRG_OFF_W-1:0]};

endmodule

// File: rtl/xbank_chr.sv
`timescale 1ns/1ps
module xbank_chr
    import xbank_pkg::*;
(
    input  map_state_t                 st,
    input  logic [CHR_OFF_W+2:0]       ppu_addr,
    output logic [CHR_W-1:0]           chr_addr
);

    reg8_t                 mask;
    logic [CHR_BANK_W-1:0] block;
    reg8_t                 src [CHR_SLOTS];
    logic [CHR_BANK_W-1:0] bank [CHR_SLOTS];
    logic [CHR_SEL_W-1:0]  slot;

    assign mask  = 8'hFF >> chr_shift(st.chr_cfg[2:0]);
    assign block = {st.outer[3:0], 11'h000}
                 | {4'h0, st.chr_hi, 8'h00}
                 | {7'h00, st.chr_cfg & ~mask};

    for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_slot
        if (s < 4) begin : g_pair
            // register 6 feeds slots 0/1, register 7 feeds slots 2/3
            assign src[s] = {st.chr_sel[4 + s/2][7:1], 1'(s % 2)};
        end else begin : g_single
            assign src[s] = st.chr_sel[s - 4];
        end
        assign bank[s] = block | {7'h00, src[s] & mask};
    end

    assign slot = ppu_addr[CHR_OFF_W+2:CHR_OFF_W] ^ {st.swap_chr, 2'b00};

    assign chr_addr = {bank[slot], ppu_addr[CHR_OFF_W-1:0]};

endmodule

// File: rtl/xbank_mapper.sv
`timescale 1ns/1ps
module xbank_mapper
    import xbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [15:0]          wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [PRG_OFF_W+1:0] cpu_addr,
    input  logic [CHR_OFF_W+2:0] ppu_addr,
    output logic [PRG_W-1:0]     prg_addr,
    output logic [CHR_W-1:0]     chr_addr,
    output logic                 mirror_horiz
);

    map_state_t st;

    xbank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .st      (st)
    );

    xbank_prg u_prg (
        .st       (st),
        .cpu_addr (cpu_addr),
        .prg_addr (prg_addr)
    );

    xbank_chr u_chr (
        .st       (st),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr)
    );

    assign mirror_horiz = st.mirror_h;

endmodule

// File: rtl/xbank_mapper_chk.sv
`timescale 1ns/1ps
module xbank_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic        wr_bit0,
    input logic [14:0] cpu_addr,
    input logic [12:0] ppu_addr,
    input logic [24:0] prg_addr,
    input logic [24:0] chr_addr,
    input logic        mirror_horiz
);

    logic        irq_slot;
    logic        legacy_other;
    logic [15:0] key;

    assign key          = wr_addr & 16'hE001;
    assign irq_slot     = (wr_addr >= 16'h4101) && (wr_addr <= 16'h4104);
    assign legacy_other = wr_addr[15] && (key != 16'h8000) && (key != 16'h8001)
                          && (key != 16'hA000);

    // R10: mirroring register follows data bit 0 one edge later
    assert_mirror_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && key == 16'hA000) |=> (mirror_horiz == $past(wr_bit0)));

    // R11: ignored writes leave every output unchanged
    assert_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (irq_slot || legacy_other)) |=>
        (!$stable(cpu_addr) || !$stable(ppu_addr) ||
         ($stable(prg_addr) && $stable(chr_addr) && $stable(mirror_horiz))));

    // R5: the $E000 window is not reachable from the legacy command pair
    assert_fixed_window_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15]) |=>
        (!$stable(cpu_addr) || cpu_addr[14:13] != 2'b11 || $stable(prg_addr)));

    // R12: offsets pass through untouched
    assert_offsets_R12: assert property (@(posedge clk) disable iff (rst)
        (prg_addr[12:0] == cpu_addr[12:0]) && (chr_addr[9:0] == ppu_addr[9:0]));

endmodule

bind xbank_mapper xbank_mapper_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_bit0      (wr_data[0]),
    .cpu_addr     (cpu_addr),
    .ppu_addr     (ppu_addr),
    .prg_addr     (prg_addr),
    .chr_addr     (chr_addr),
    .mirror_horiz (mirror_horiz)
);

// File: tb/xbank_mapper_tb.sv
`timescale 1ns/10ps
module xbank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [14:0] cpu_addr = '0;
    logic [12:0] ppu_addr = '0;
    logic [24:0] prg_addr;
    logic [24:0] chr_addr;
    logic        mirror_horiz;

    int n_checks = 0;
    int n_fail   = 0;
    bit live     = 1'b0;

    // behavioural model state
    int m410 [16];
    int m201 [16];
    int mcmd;
    int mmir;

    always #10 clk = ~clk;   // 50 MHz

    xbank_mapper u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cpu_addr     (cpu_addr),
        .ppu_addr     (ppu_addr),
        .prg_addr     (prg_addr),
        .chr_addr     (chr_addr),
        .mirror_horiz (mirror_horiz)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin
            m410[i] = 0;
            m201[i] = 0;
        end
        mcmd = 0;
        mmir = 0;
    endfunction

    function automatic void model_write(input int a, input int d);
        int k;
        k = a & 16'hE001;
        if ((a >> 4) == 16'h410) begin
            if ((a & 15) < 1 || (a & 15) > 4) m410[a & 15] = d;
        end else if ((a >> 4) == 16'h201) begin
            m201[a & 15] = d;
        end else if (a >= 16'h8000) begin
            if (k == 16'h8000) mcmd = (mcmd & 8'h38) | (d & 8'hC7);
            else if (k == 16'hA000) mmir = d & 1;
            else if (k == 16'h8001) begin
                case (mcmd & 7)
                    0: m201[6] = d;
                    1: m201[7] = d;
                    2: m201[2] = d;
                    3: m201[3] = d;
                    4: m201[4] = d;
                    5: m201[5] = d;
                    6: m410[7] = d;
                    default: m410[8] = d;
                endcase
            end
        end
    endfunction

    function automatic int exp_prg(input int a);
        int w, mode, mask, blk, v;
        w = (a >> 13) & 3;
        if ((mcmd & 64) != 0 && (w == 0 || w == 2)) w = 2 - w;
        mode = m410[11] & 7;
        mask = (mode == 7) ? 255 : (63 >> mode);
        blk  = ((m410[0] & 240) << 4) + (m410[10] & ~mask & 255);
        case (w)
            0: v = m410[7];
            1: v = m410[8];
            2: v = ((m410[11] & 64) != 0) ? m410[9] : 254;
            default: v = 255;
        endcase
        return ((blk | (v & mask)) << 13) | (a & 16'h1FFF);
    endfunction

    function automatic int exp_chr(input int a);
        int s, sh, mask, blk, v;
        s = (a >> 10) & 7;
        if ((mcmd & 128) != 0) s = s ^ 4;
        case (m201[10] & 7)
            1: sh = 1;
            2: sh = 2;
            4: sh = 3;
            5: sh = 4;
            6: sh = 5;
            default: sh = 0;
        endcase
        mask = 255 >> sh;
        blk  = ((m410[0] & 15) << 11) + ((m201[8] & 112) << 4) + (m201[10] & ~mask & 255);
        case (s)
            0: v = m201[6] & 254;
            1: v = m201[6] | 1;
            2: v = m201[7] & 254;
            3: v = m201[7] | 1;
            default: v = m201[s - 2];
        endcase
        return ((blk | (v & mask)) << 10) | (a & 10'h3FF);
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 16'(a);
        wr_data = 8'(d);
        @(posedge clk);
        #1;
        model_write(a, d);
        wr_en = 1'b0;
    endtask

    // all windows and slots, finished before the following falling edge
    task automatic sweep(input string tag);
        @(posedge clk);
        #1;
        for (int w = 0; w < 4; w++) begin
            cpu_addr = 15'((w << 13) | (w * 16'h0123));
            #0.7;
            chk({tag, " prg R4 R5 R6"}, int'(prg_addr), exp_prg(int'(cpu_addr)));
        end
        for (int s = 0; s < 8; s++) begin
            ppu_addr = 13'((s << 10) | (s * 10'h045));
            #0.7;
            chk({tag, " chr R7 R8 R9"}, int'(chr_addr), exp_chr(int'(ppu_addr)));
        end
        chk({tag, " mirror R10"}, int'(mirror_horiz), mmir);
    endtask

    // per-cycle comparison at the applied addresses (R12)
    always @(negedge clk) begin
        if (live && !rst) begin
            chk("cycle prg R12", int'(prg_addr), exp_prg(int'(cpu_addr)));
            chk("cycle chr R12", int'(chr_addr), exp_chr(int'(ppu_addr)));
        end
    end

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state, hand-computed
        cpu_addr = 15'h0000; #0.5; chk("R1 prg $8000", int'(prg_addr), 32'h0);
        cpu_addr = 15'h2005; #0.5; chk("R1 prg $A000", int'(prg_addr), 32'h5);
        cpu_addr = 15'h4000; #0.5; chk("R1 prg $C000", int'(prg_addr), 32'h3E << 13);
        cpu_addr = 15'h6000; #0.5; chk("R1 prg $E000", int'(prg_addr), 32'h3F << 13);
        ppu_addr = 13'h0400; #0.5; chk("R1 chr slot1", int'(chr_addr), 32'h400);
        ppu_addr = 13'h0C00; #0.5; chk("R1 chr slot3", int'(chr_addr), 32'h400);
        ppu_addr = 13'h1C00; #0.5; chk("R1 chr slot7", int'(chr_addr), 32'h0);
        chk("R1 mirror", int'(mirror_horiz), 0);
        live = 1'b1;

        // R3 dispatch through the command pair
        for (int i = 0; i < 8; i++) begin
            wr(16'h8000, i);
            wr(16'h8001, 8'h11 * (i + 1) + 8'h20);
        end
        sweep("R3 dispatch");

        // R2 command merge: bits 5:3 never stick, swaps follow bits 7/6
        wr(16'h8000, 8'hFF);
        sweep("R2 cmd all");
        wr(16'h8001, 8'h5A);
        sweep("R2 cmd idx7");
        wr(16'h8000, 8'h46);
        wr(16'h8001, 8'hC3);
        sweep("R6 prg swap");
        wr(16'h8000, 8'h80);
        sweep("R9 chr swap");

        // R4 R5 program size modes, window 2 source select
        wr(16'h4100, 8'hA5);
        wr(16'h410A, 8'hC3);
        wr(16'h4109, 8'h9D);
        wr(16'h4107, 8'h6E);
        for (int m = 0; m < 8; m++) begin
            wr(16'h410B, m | ((m & 1) << 6));
            sweep("R4 R5 mode");
        end

        // R7 R8 pattern size modes and direct register file
        wr(16'h2018, 8'h5F);
        wr(16'h201A, 8'hB8);
        for (int r = 2; r < 8; r++) wr(16'h2010 + r, 8'h37 * r);
        for (int m = 0; m < 8; m++) begin
            wr(16'h201A, 8'hA8 | m);
            sweep("R7 R8 mode");
        end

        // R10 mirroring
        wr(16'hA000, 8'h01);
        sweep("R10 set");
        wr(16'hA001, 8'h00);
        sweep("R11 A001");
        wr(16'hBFFE, 8'hFE);
        sweep("R10 alias clear");

        // R11 ignored writes
        for (int a = 16'h4101; a <= 16'h4104; a++) begin
            wr(a, 8'hFF);
            sweep("R11 irq slot");
        end
        wr(16'hC000, 8'hFF);
        wr(16'hE001, 8'h00);
        wr(16'hC001, 8'h12);
        sweep("R11 legacy other");

        // R1 reset again after heavy state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        model_reset();
        rst = 1'b0;
        sweep("R1 re-reset");

        live = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule